// File: doc/BRIEF.md
# Path Remote Error Indication Generator

This block builds the 4-bit path remote error indication that a transmitter places in the upper nibble of the G1 byte on each of several STS-1 channels (three by default). For every channel the receive side hands over the received B3 byte and the BIP-8 it computed locally over the same frame. The block counts the bit positions in which the two differ, holds that count, and sends it back in the next outgoing frame. The returned value lies between 0 and 8.

A processor can turn off automatic reporting per channel. A turned-off channel normally sends 0. When the processor fires a single-cycle insert pulse, every turned-off channel sends exactly one error in the next outgoing frame. A protection-select input swaps every channel over to REI values supplied by a protection board. A mode input selects a single-channel STM-1 arrangement, in which only channel 0 carries a value and only its inhibit bit counts.

Two state machines control the behaviour. The insert controller has the states `INS_IDLE` and `INS_ARMED`. A pulse moves it from `INS_IDLE` to `INS_ARMED`, and it stays armed until a frame strobe. A frame strobe returns it to `INS_IDLE`, unless a new pulse arrives in the same cycle, in which case it stays in `INS_ARMED`. Each channel selector records the source it used for the frame that just started. The source is one of `SRC_OFF` (channel unused), `SRC_LOCAL` (measured count), `SRC_FORCED` (inhibited; 1 if armed, else 0) or `SRC_PROT` (protection board). On every frame strobe the selector moves to whichever source the current inputs select, with the priority order OFF, PROT, FORCED, LOCAL.

Top module: `path_rei_gen`

## Requirements
- R1: On a cycle where `err_valid[c]` is 1, channel c stores the number of bits set in `b3_rx[c] ^ bip_calc[c]`. That value appears in `rei_out[4c+3:4c]` on the next `frame_start` edge. Once sent, the stored count drops to 0, so a frame with no new measurement reports 0.
- R2: No `rei_out` nibble ever exceeds 8. A protection value of 9 to 15 is sent as 8.
- R3: A channel whose effective inhibit is 1 never sends its measured count. With no armed insert request, it sends 0.
- R4: An `ins_pulse` arms one request. At the next `frame_start`, each inhibited channel sends exactly 1, however many pulses arrived. The following frame sends 0 again.
- R5: A pulse in the same cycle as `frame_start` is not used for that frame. It is applied at the next `frame_start`.
- R6: A channel that is not inhibited ignores `ins_pulse` and sends its measured count.
- R7: When `stm1_mode` is 1, channel 0 uses `inhibit[0]`. All other channels send 0 whatever their inhibit bits and measurements.
- R8: When `prot_sel` is 1 at `frame_start`, each active channel sends its `prot_rei` nibble. The pending local count and any armed request are still used up by that frame.
- R9: `rei_out` is 0 after reset and changes only on a `frame_start` edge.
- R10: A measurement in the same cycle as `frame_start` does not change that frame. The earlier count is sent, and the new one is held for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of each outgoing frame |
| err_valid | input | NCH | Per-channel strobe: B3 comparison data valid |
| b3_rx | input | NCH*8 | Received B3 byte per channel (channel c at bits 8c+7:8c) |
| bip_calc | input | NCH*8 | Locally computed BIP-8 per channel |
| inhibit | input | NCH | Per-channel automatic reporting inhibit |
| ins_pulse | input | 1 | Processor single-error insert pulse |
| stm1_mode | input | 1 | 1 = single-channel STM-1, 0 = three STS-1 channels |
| prot_sel | input | 1 | 1 = take REI values from protection board |
| prot_rei | input | NCH*4 | Protection-board REI nibble per channel |
| rei_out | output | NCH*4 | REI nibble per channel (channel c at bits 4c+3:4c) |

## Verification
Every result is due one cycle after the frame strobe that carries it. A value is written into the output register on the same rising edge that samples `frame_start`. Measurements and insert pulses therefore always show up one full frame strobe later, or two when they coincide with a strobe. The bench drives all inputs on falling edges. For each strobe it queues one expected triple of nibbles, and the monitor compares that triple on the falling edge after the strobe's rising edge. Hold checks between strobes sample several falling edges after the last strobe and expect no change.

// File: rtl/rei_pkg.sv
package rei_pkg;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_LOCAL  = 2'd1,
        SRC_FORCED = 2'd2,
        SRC_PROT   = 2'd3
    } rei_src_e;

    typedef enum logic {
        INS_IDLE  = 1'b0,
        INS_ARMED = 1'b1
    } ins_state_e;

endpackage

// File: rtl/rei_err_count.sv
module rei_err_count #(
    parameter int BIP_W = 8,
    parameter int CW    = $clog2(BIP_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             err_valid,
    input  logic [BIP_W-1:0] b3_rx,
    input  logic [BIP_W-1:0] bip_calc,
    output logic [CW-1:0]    cnt
);

    logic [BIP_W-1:0] diff;
    logic [CW-1:0]    meas;

    always_comb begin
        diff = b3_rx ^ bip_calc;
        meas = '0;
        for (int i = 0; i < BIP_W; i++) begin
            meas = meas + CW'(diff[i]);
        end
    end

    // A fresh measurement always wins; otherwise a frame strobe drains the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (err_valid) begin
            cnt <= meas;
        end else if (frame_start) begin
            cnt <= '0;
        end
    end

    AST_CNT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !err_valid |=> cnt == '0);  // R1

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> cnt <= CW'(BIP_W));  // R2

endmodule

// File: rtl/rei_ins_ctrl.sv
module rei_ins_ctrl
    import rei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic ins_pulse,
    output logic ins_req
);

    ins_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INS_IDLE: begin
                if (ins_pulse) state_d = INS_ARMED;
            end
            INS_ARMED: begin
                if (frame_start && !ins_pulse) state_d = INS_IDLE;
            end
            default: state_d = INS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= INS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ins_req = (state_q == INS_ARMED);
    end

    AST_PULSE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ins_pulse |=> ins_req);  // R4

    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req && !frame_start |=> ins_req);  // R4

    AST_FRAME_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !ins_pulse |=> !ins_req);  // R5

endmodule

// File: rtl/rei_chan_sel.sv
module rei_chan_sel
    import rei_pkg::*;
#(
    parameter int BIP_W = 8,
    parameter int CW    = $clog2(BIP_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          chan_en,
    input  logic          inh,
    input  logic          prot_sel,
    input  logic [CW-1:0] prot_val,
    input  logic [CW-1:0] local_cnt,
    input  logic          ins_req,
    output logic [CW-1:0] rei
);

    localparam logic [CW-1:0] CNT_MAX = CW'(BIP_W);

    rei_src_e src_q, src_d;
    logic [CW-1:0] prot_clamped;

    always_comb begin
        prot_clamped = (prot_val > CNT_MAX) ? CNT_MAX : prot_val;
        if (!chan_en)      src_d = SRC_OFF;
        else if (prot_sel) src_d = SRC_PROT;
        else if (inh)      src_d = SRC_FORCED;
        else               src_d = SRC_LOCAL;
    end

    // State register: source used by the current outgoing frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           src_q <= SRC_OFF;
        else if (frame_start) src_q <= src_d;
    end

    // Output register: REI nibble for the current outgoing frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rei <= '0;
        end else if (frame_start) begin
            unique case (src_d)
                SRC_OFF:    rei <= '0;
                SRC_LOCAL:  rei <= local_cnt;
                SRC_FORCED: rei <= ins_req ? CW'(1) : '0;
                SRC_PROT:   rei <= prot_clamped;
                default:    rei <= '0;
            endcase
        end
    end

    AST_REI_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        rei <= CNT_MAX);  // R2

    AST_FORCED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        src_q == SRC_FORCED |-> rei <= CW'(1));  // R3

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        src_q == SRC_OFF |-> rei == '0);  // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(rei));  // R9

endmodule

// File: rtl/path_rei_gen.sv
module path_rei_gen #(
    parameter int NCH   = 3,
    parameter int BIP_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  frame_start,
    input  logic [NCH-1:0]                        err_valid,
    input  logic [NCH*BIP_W-1:0]                  b3_rx,
    input  logic [NCH*BIP_W-1:0]                  bip_calc,
    input  logic [NCH-1:0]                        inhibit,
    input  logic                                  ins_pulse,
    input  logic                                  stm1_mode,
    input  logic                                  prot_sel,
    input  logic [NCH*$clog2(BIP_W+1)-1:0]        prot_rei,
    output logic [NCH*$clog2(BIP_W+1)-1:0]        rei_out
);

    localparam int CW = $clog2(BIP_W + 1);

    logic ins_req;

    rei_ins_ctrl u_ins (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .ins_pulse   (ins_pulse),
        .ins_req     (ins_req)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CW-1:0] cnt;
        logic          chan_en;
        logic          inh_eff;

        if (c == 0) begin : g_lead
            always_comb begin
                chan_en = 1'b1;
                inh_eff = inhibit[0];
            end
        end else begin : g_trib
            always_comb begin
                chan_en = !stm1_mode;
                inh_eff = inhibit[c];
            end
        end

        rei_err_count #(.BIP_W(BIP_W), .CW(CW)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .err_valid   (err_valid[c]),
            .b3_rx       (b3_rx[c*BIP_W +: BIP_W]),
            .bip_calc    (bip_calc[c*BIP_W +: BIP_W]),
            .cnt         (cnt)
        );

        rei_chan_sel #(.BIP_W(BIP_W), .CW(CW)) u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .chan_en     (chan_en),
            .inh         (inh_eff),
            .prot_sel    (prot_sel),
            .prot_val    (prot_rei[c*CW +: CW]),
            .local_cnt   (cnt),
            .ins_req     (ins_req),
            .rei         (rei_out[c*CW +: CW])
        );
    end

    if (NCH > 1) begin : g_stm1_chk
        AST_STM1_TRIB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            frame_start && stm1_mode |=> rei_out[NCH*CW-1:CW] == '0);  // R7
    end

    AST_PROT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && prot_sel && prot_rei[CW-1:0] <= CW'(BIP_W)
        |=> rei_out[CW-1:0] == $past(prot_rei[CW-1:0]));  // R8

endmodule

// File: tb/path_rei_gen_tb.sv
module path_rei_gen_tb;

    localparam int NCH = 3;
    localparam int BW  = 8;
    localparam int CW  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [NCH-1:0]    err_valid = '0;
    logic [NCH*BW-1:0] b3_rx = '0;
    logic [NCH*BW-1:0] bip_calc = '0;
    logic [NCH-1:0]    inhibit = '0;
    logic              ins_pulse = 1'b0;
    logic              stm1_mode = 1'b0;
    logic              prot_sel = 1'b0;
    logic [NCH*CW-1:0] prot_rei = '0;
    logic [NCH*CW-1:0] rei_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [NCH*CW-1:0] val;
        string             tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    path_rei_gen #(.NCH(NCH), .BIP_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .err_valid(err_valid), .b3_rx(b3_rx), .bip_calc(bip_calc),
        .inhibit(inhibit), .ins_pulse(ins_pulse), .stm1_mode(stm1_mode),
        .prot_sel(prot_sel), .prot_rei(prot_rei), .rei_out(rei_out)
    );

    task automatic check(input logic [NCH*CW-1:0] act, input logic [NCH*CW-1:0] exp,
                         input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Load one channel's measurement inputs (count = ones in rx ^ calc).
    task automatic set_meas(input int ch, input logic [BW-1:0] rx, input logic [BW-1:0] calc);
        err_valid[ch] = 1'b1;
        b3_rx[ch*BW +: BW] = rx;
        bip_calc[ch*BW +: BW] = calc;
    endtask

    task automatic measure(input int ch, input logic [BW-1:0] rx, input logic [BW-1:0] calc);
        @(negedge clk);
        set_meas(ch, rx, calc);
        @(negedge clk);
        err_valid = '0;
    endtask

    task automatic pulse();
        @(negedge clk);
        ins_pulse = 1'b1;
        @(negedge clk);
        ins_pulse = 1'b0;
    endtask

    // Driver: one frame strobe, expected nibbles pushed into the scoreboard.
    task automatic frame(input logic [CW-1:0] e0, input logic [CW-1:0] e1,
                         input logic [CW-1:0] e2, input string tag,
                         input bit with_pulse = 0, input bit with_meas = 0,
                         input logic [BW-1:0] mrx = '0);
        exp_t e;
        @(negedge clk);
        e.val = {e2, e1, e0};
        e.tag = tag;
        sb.push_back(e);
        frame_start = 1'b1;
        if (with_pulse) ins_pulse = 1'b1;
        if (with_meas)  set_meas(0, mrx, 8'h00);
        @(negedge clk);
        frame_start = 1'b0;
        ins_pulse = 1'b0;
        err_valid = '0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: result due on the edge that samples the strobe.
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && frame_start) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL scoreboard: actual %h expected none", rei_out);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rei_out, e.val, e.tag);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NCH*CW-1:0] snap;
        repeat (3) @(negedge clk);
        check(rei_out, '0, "R9 reset value");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: counts 8, 4, 1
        measure(0, 8'hFF, 8'h00);
        measure(1, 8'h0F, 8'h00);
        measure(2, 8'hA5, 8'hA4);
        frame(4'd8, 4'd4, 4'd1, "R1 popcount per channel");

        // R9: hold between strobes while other inputs move
        snap = rei_out;
        @(negedge clk);
        prot_sel = 1'b1; inhibit = 3'b111; prot_rei = 12'h777;
        repeat (3) @(negedge clk);
        check(rei_out, snap, "R9 hold without strobe");
        prot_sel = 1'b0; inhibit = '0; prot_rei = '0;
        pulse();
        repeat (2) @(negedge clk);
        check(rei_out, snap, "R9 hold after pulse");

        // R1 drain, R6 pulse ignored by uninhibited channels
        frame(4'd0, 4'd0, 4'd0, "R1 R6 drained count, pulse ignored");

        // R4 / R6: ch1 inhibited, three pulses -> single error
        @(negedge clk); inhibit = 3'b010;
        measure(0, 8'h07, 8'h00);
        measure(1, 8'h07, 8'h00);
        measure(2, 8'h70, 8'h00);
        pulse(); pulse(); pulse();
        frame(4'd3, 4'd1, 4'd3, "R4 R6 forced single error");
        frame(4'd0, 4'd0, 4'd0, "R4 one frame only");

        // R3: inhibited, no pulse, count withheld
        measure(1, 8'h1F, 8'h00);
        frame(4'd0, 4'd0, 4'd0, "R3 inhibited sends zero");

        // R5: pulse coincident with strobe
        frame(4'd0, 4'd0, 4'd0, "R5 coincident pulse deferred", 1'b1);
        frame(4'd0, 4'd1, 4'd0, "R5 deferred pulse applied");

        // R10: measurement coincident with strobe
        measure(0, 8'h03, 8'h00);
        frame(4'd2, 4'd0, 4'd0, "R10 old count sent", 1'b0, 1'b1, 8'h3F);
        frame(4'd6, 4'd0, 4'd0, "R10 new count next frame");

        // R7: STM-1, only ch0 active; ch1/ch2 inhibits ignored
        @(negedge clk); stm1_mode = 1'b1; inhibit = 3'b110;
        measure(0, 8'h7F, 8'h00);
        measure(1, 8'h7F, 8'h00);
        measure(2, 8'h7F, 8'h00);
        pulse();
        frame(4'd7, 4'd0, 4'd0, "R7 stm1 ch0 local, tribs zero");
        @(negedge clk); inhibit = 3'b001;
        measure(0, 8'h0F, 8'h00);
        pulse();
        frame(4'd1, 4'd0, 4'd0, "R7 stm1 ch0 inhibit honoured");

        // R8 / R2: protection source with clamp
        @(negedge clk); stm1_mode = 1'b0; inhibit = '0;
        prot_sel = 1'b1; prot_rei = {4'd0, 4'd12, 4'd5};
        measure(0, 8'h07, 8'h00);
        frame(4'd5, 4'd8, 4'd0, "R8 R2 protection values clamped");
        @(negedge clk); prot_sel = 1'b0; prot_rei = {4'd15, 4'd15, 4'd15};
        frame(4'd0, 4'd0, 4'd0, "R8 local count consumed");
        @(negedge clk); prot_sel = 1'b1;
        frame(4'd8, 4'd8, 4'd8, "R2 all-ones protection clamped");
        @(negedge clk); prot_sel = 1'b0;

        repeat (4) @(negedge clk);
        check(NCH*CW'(sb.size()), '0, "scoreboard drained");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule